// File: doc/BRIEF.md
# Priority-Ordered Descriptor Queue

This block holds cell descriptors in one ordered storage array. It serves them as if they sat in several first-in first-out queues, one per class, with the highest class always served first. Each arriving descriptor carries a class number and a tag. The block does not append it at the tail. It slots the descriptor in directly behind the last stored entry whose class is equal to or more urgent than its own. Every less urgent entry moves one place toward the tail.

A consumer only ever takes the entry at the front of the array. It sees that entry combinationally on the head outputs, together with an empty flag. A producer sees a full flag. A push made while the queue is full is refused, and a drop strobe is raised in the same cycle. A pop and a push in the same cycle are both carried out. The pop leaves first, and the insertion point is then worked out on the shortened queue.

Top module: `pifo_queue`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, and `head_cls` and `head_tag` read 0.
- R2: Class 0 is the most urgent class and larger class numbers are less urgent. The head is always an entry of the smallest class number held, and the stored entries stay sorted by non-decreasing class from head to tail. A pushed class must be below NUM_CLS.
- R3: Entries of one class leave in the order in which they were accepted.
- R4: An accepted entry is placed right behind the last stored entry whose class is less than or equal to its own. It therefore overtakes every queued entry of a larger class number and queues behind every entry of an equal class.
- R5: A pop (`pop_rdy`=1 while not empty) removes only the head entry. The former second entry becomes the head, and the relative order of the others is unchanged.
- R6: When a push and a pop are both performed in one cycle, the old head is removed first and the new entry is then inserted into the remaining entries. A push together with a pop on an empty queue stores the push and removes nothing.
- R7: `push_drop` equals `push_vld` AND `full` in the same cycle. A dropped push leaves the stored contents untouched, while a pop in that cycle is still performed.
- R8: A pop while empty changes nothing, and `head_cls`/`head_tag` read 0 while empty.
- R9: `full` is 1 exactly when DEPTH entries are stored, and `empty` is 1 exactly when none are.
- R10: An accepted push is visible on the head outputs from the next cycle on if it became the head. With neither push nor pop, the head outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_vld | input | 1 | Insert a descriptor this cycle |
| push_cls | input | CLS_W | Class of the new descriptor, 0 is most urgent |
| push_tag | input | TAG_W | Tag of the new descriptor |
| push_drop | output | 1 | The push of this cycle is refused because the queue is full |
| pop_rdy | input | 1 | Remove the head entry this cycle |
| head_cls | output | CLS_W | Class of the head entry, 0 when empty |
| head_tag | output | TAG_W | Tag of the head entry, 0 when empty |
| empty | output | 1 | No entry stored |
| full | output | 1 | DEPTH entries stored |

## Verification
The bench aims at the insertion point. It checks that an urgent arrival overtakes queued entries of larger class numbers and lands behind entries of its own class. A comparator that used strict less-than in the wrong direction would give a reversed FIFO order, and an off-by-one insert index would place the entry one slot early or late.

The same-cycle push and pop is driven both on a queue holding only a less urgent class and on an empty queue. If the insert index were computed before the pop, the new entry would be placed one slot too far back, or the empty-queue push would be lost.

Pushes made while full, both with and without a pop in the same cycle, expose a design that overwrites the tail or grows past its depth. Pops made while empty expose a design that shifts stale data to the head. A long mixed-traffic run is compared step by step against an arithmetic queue model.

// File: rtl/pq_pkg.sv
package pq_pkg;

   // Source a storage slot loads from on the next edge.
   typedef enum logic [1:0] {
      SRC_SAME   = 2'd0,   // keep position (own entry, or the one behind after a pop)
      SRC_NEW    = 2'd1,   // the incoming descriptor lands here
      SRC_BEHIND = 2'd2    // displaced one place toward the tail
   } slot_src_e;

   function automatic int cls_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pq_occupancy.sv
module pq_occupancy #(
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop_do,
   input  logic             push_do,
   output logic [DEPTH-1:0] vld,
   output logic             full,
   output logic             empty
);

   logic [DEPTH-1:0] after_pop;
   logic [DEPTH-1:0] vld_nxt;

   // Occupancy is a thermometer: slot i holds an entry iff i < count.
   always_comb begin
      after_pop = pop_do ? (vld >> 1) : vld;
      vld_nxt   = push_do ? {after_pop[DEPTH-2:0], 1'b1} : after_pop;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) vld <= '0;
      else        vld <= vld_nxt;
   end

   assign full  = vld[DEPTH-1];
   assign empty = ~vld[0];

   AST_VLD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      ((vld + DEPTH'(1)) & vld) == '0);   // R9

endmodule

// File: rtl/pq_slot.sv
module pq_slot #(
   parameter int CLS_W = 2,
   parameter int TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop_do,
   input  logic             push_do,
   input  logic [CLS_W-1:0] in_cls,
   input  logic [TAG_W-1:0] in_tag,
   input  logic             vld,
   input  logic             here_eff,
   input  logic             prev_eff,
   input  logic [CLS_W-1:0] nxt_cls,
   input  logic [TAG_W-1:0] nxt_tag,
   input  logic [CLS_W-1:0] prv_cls,
   input  logic [TAG_W-1:0] prv_tag,
   output logic             ahead_raw,
   output logic [CLS_W-1:0] cls_q,
   output logic [TAG_W-1:0] tag_q
);
   import pq_pkg::*;

   slot_src_e        sel;
   logic [CLS_W-1:0] cls_d;
   logic [TAG_W-1:0] tag_d;

   // This entry stays in front of a newcomer when it is at least as urgent.
   assign ahead_raw = vld && (cls_q <= in_cls);

   // here_eff / prev_eff describe the queue after any pop of this cycle.
   always_comb begin
      if (!push_do || here_eff) sel = SRC_SAME;
      else if (prev_eff)        sel = SRC_NEW;
      else                      sel = SRC_BEHIND;
   end

   always_comb begin
      case (sel)
         SRC_NEW: begin
            cls_d = in_cls;
            tag_d = in_tag;
         end
         SRC_BEHIND: begin
            cls_d = pop_do ? cls_q : prv_cls;
            tag_d = pop_do ? tag_q : prv_tag;
         end
         default: begin
            cls_d = pop_do ? nxt_cls : cls_q;
            tag_d = pop_do ? nxt_tag : tag_q;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cls_q <= '0;
         tag_q <= '0;
      end else begin
         cls_q <= cls_d;
         tag_q <= tag_d;
      end
   end

endmodule

// File: rtl/pifo_queue.sv
module pifo_queue #(
   parameter int NUM_CLS = 3,
   parameter int DEPTH   = 8,
   parameter int TAG_W   = 8,
   parameter int CLS_W   = pq_pkg::cls_width(NUM_CLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_vld,
   input  logic [CLS_W-1:0] push_cls,
   input  logic [TAG_W-1:0] push_tag,
   output logic             push_drop,
   input  logic             pop_rdy,
   output logic [CLS_W-1:0] head_cls,
   output logic [TAG_W-1:0] head_tag,
   output logic             empty,
   output logic             full
);

   localparam logic [CLS_W:0] CLS_LIM = (CLS_W+1)'(NUM_CLS);

   initial begin
      AST_PARAM_DEPTH: assert (DEPTH >= 2);                               // R9
      AST_PARAM_CLS:   assert (NUM_CLS >= 2);                             // R2
      AST_PARAM_CLSW:  assert (CLS_W == pq_pkg::cls_width(NUM_CLS));      // R2
      AST_PARAM_TAG:   assert (TAG_W >= 1);                               // R10
   end

   logic             pop_do;
   logic             push_do;
   logic [DEPTH-1:0] vld;
   logic [DEPTH:0]   ahead_ext;
   logic [DEPTH-1:0] ahead_eff;
   logic [CLS_W-1:0] cls_q [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];

   assign pop_do    = pop_rdy  & ~empty;
   assign push_do   = push_vld & ~full;
   assign push_drop = push_vld &  full;

   pq_occupancy #(.DEPTH(DEPTH)) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .pop_do  (pop_do),
      .push_do (push_do),
      .vld     (vld),
      .full    (full),
      .empty   (empty)
   );

   assign ahead_ext[DEPTH] = 1'b0;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [CLS_W-1:0] nxt_cls, prv_cls;
      logic [TAG_W-1:0] nxt_tag, prv_tag;
      logic             prev_eff;

      // After a pop, slot i faces what slot i+1 holds now.
      assign ahead_eff[i] = pop_do ? ahead_ext[i+1] : ahead_ext[i];

      if (i == DEPTH - 1) begin : g_tail
         assign nxt_cls = '0;
         assign nxt_tag = '0;
      end else begin : g_mid
         assign nxt_cls = cls_q[i+1];
         assign nxt_tag = tag_q[i+1];
      end

      if (i == 0) begin : g_head
         assign prv_cls  = '0;
         assign prv_tag  = '0;
         assign prev_eff = 1'b1;
      end else begin : g_body
         assign prv_cls  = cls_q[i-1];
         assign prv_tag  = tag_q[i-1];
         assign prev_eff = ahead_eff[i-1];
      end

      pq_slot #(.CLS_W(CLS_W), .TAG_W(TAG_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .pop_do    (pop_do),
         .push_do   (push_do),
         .in_cls    (push_cls),
         .in_tag    (push_tag),
         .vld       (vld[i]),
         .here_eff  (ahead_eff[i]),
         .prev_eff  (prev_eff),
         .nxt_cls   (nxt_cls),
         .nxt_tag   (nxt_tag),
         .prv_cls   (prv_cls),
         .prv_tag   (prv_tag),
         .ahead_raw (ahead_ext[i]),
         .cls_q     (cls_q[i]),
         .tag_q     (tag_q[i])
      );

      if (i < DEPTH - 1) begin : g_order
         AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
            vld[i+1] |-> (cls_q[i] <= cls_q[i+1]));                        // R2
      end
   end

   assign head_cls = empty ? '0 : cls_q[0];
   assign head_tag = empty ? '0 : tag_q[0];

   AST_CLS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      push_vld |-> ({1'b0, push_cls} < CLS_LIM));                          // R2
   AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (push_vld && full && !pop_rdy) |=> full);                            // R7
   AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop_rdy && !push_vld) |=> empty);                          // R8
   AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_vld && !full) |=> !empty);                                     // R6
   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_vld && !pop_rdy) |=> ($stable(head_tag) && $stable(head_cls))); // R10
   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (head_tag == '0 && head_cls == '0));                       // R8

endmodule

// File: tb/sim_pifo_queue.sv
`timescale 1ns/1ps
module sim_pifo_queue;

   localparam int NCLS  = 3;
   localparam int DEPTH = 8;
   localparam int TW    = 8;
   localparam int CW    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_vld = 1'b0;
   logic [CW-1:0] push_cls = '0;
   logic [TW-1:0] push_tag = '0;
   logic          pop_rdy = 1'b0;
   logic          push_drop, empty, full;
   logic [CW-1:0] head_cls;
   logic [TW-1:0] head_tag;

   always #2.5 clk = ~clk;

   pifo_queue #(.NUM_CLS(NCLS), .DEPTH(DEPTH), .TAG_W(TW)) u0 (
      .clk (clk), .rst_n (rst_n),
      .push_vld (push_vld), .push_cls (push_cls), .push_tag (push_tag),
      .push_drop (push_drop), .pop_rdy (pop_rdy),
      .head_cls (head_cls), .head_tag (head_tag),
      .empty (empty), .full (full)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int            m_cnt = 0;
   logic [CW-1:0] m_cls [DEPTH];
   logic [TW-1:0] m_tag [DEPTH];

   task automatic chk(input string rq, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic check_state(input string rq);
      chk(rq, "empty", int'(empty), int'(m_cnt == 0));
      chk(rq, "full", int'(full), int'(m_cnt == DEPTH));
      chk(rq, "head_cls", int'(head_cls), (m_cnt > 0) ? int'(m_cls[0]) : 0);
      chk(rq, "head_tag", int'(head_tag), (m_cnt > 0) ? int'(m_tag[0]) : 0);
   endtask

   // Reference queue: pop first, then insert after the last entry of class <= new.
   task automatic model_step(input bit pv, input logic [CW-1:0] pc,
                             input logic [TW-1:0] pt, input bit pr);
      bit was_full = (m_cnt == DEPTH);
      int p = 0;
      if (pr && m_cnt > 0) begin
         for (int j = 0; j < m_cnt - 1; j++) begin
            m_cls[j] = m_cls[j+1];
            m_tag[j] = m_tag[j+1];
         end
         m_cnt--;
      end
      if (pv && !was_full) begin
         for (int j = 0; j < m_cnt; j++)
            if (m_cls[j] <= pc) p = j + 1;
         for (int j = m_cnt; j > p; j--) begin
            m_cls[j] = m_cls[j-1];
            m_tag[j] = m_tag[j-1];
         end
         m_cls[p] = pc;
         m_tag[p] = pt;
         m_cnt++;
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input bit pv, input logic [CW-1:0] pc,
                       input logic [TW-1:0] pt, input bit pr, input string rq);
      push_vld = pv; push_cls = pc; push_tag = pt; pop_rdy = pr;
      #1;
      chk("R7", "push_drop", int'(push_drop), int'(pv && (m_cnt == DEPTH)));
      @(posedge clk);
      model_step(pv, pc, pt, pr);
      @(negedge clk);
      push_vld = 1'b0; pop_rdy = 1'b0;
      check_state(rq);
   endtask

   task automatic drain(input string rq);
      while (m_cnt > 0) step(1'b0, '0, '0, 1'b1, rq);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_state("R1");
      chk("R1", "empty_at_reset", int'(empty), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: urgent arrivals overtake, equal class queues behind
      step(1'b1, 2'd2, 8'h21, 1'b0, "R4");
      step(1'b1, 2'd2, 8'h22, 1'b0, "R4");
      step(1'b1, 2'd1, 8'h11, 1'b0, "R10");
      chk("R10", "head_after_push", int'(head_tag), 'h11);
      step(1'b1, 2'd0, 8'h01, 1'b0, "R4");
      chk("R4", "head_tag", int'(head_tag), 'h01);
      step(1'b1, 2'd1, 8'h12, 1'b0, "R4");
      step(1'b0, '0, '0, 1'b0, "R10");
      chk("R10", "hold", int'(head_tag), 'h01);
      step(1'b0, '0, '0, 1'b1, "R5");
      chk("R5", "second_becomes_head", int'(head_tag), 'h11);
      step(1'b0, '0, '0, 1'b1, "R5");
      chk("R4", "equal_class_behind", int'(head_tag), 'h12);
      step(1'b0, '0, '0, 1'b1, "R5");
      chk("R3", "fifo_class2", int'(head_tag), 'h21);
      drain("R5");

      // R3: FIFO within one class
      step(1'b1, 2'd1, 8'h31, 1'b0, "R3");
      step(1'b1, 2'd1, 8'h32, 1'b0, "R3");
      step(1'b1, 2'd1, 8'h33, 1'b0, "R3");
      step(1'b0, '0, '0, 1'b1, "R3");
      chk("R3", "fifo_order", int'(head_tag), 'h32);
      drain("R3");

      // R6: simultaneous push and pop
      step(1'b1, 2'd2, 8'h40, 1'b0, "R6");
      step(1'b1, 2'd2, 8'h41, 1'b0, "R6");
      step(1'b1, 2'd0, 8'h50, 1'b1, "R6");
      chk("R6", "new_head", int'(head_tag), 'h50);
      step(1'b0, '0, '0, 1'b1, "R6");
      chk("R6", "old_head_gone", int'(head_tag), 'h41);
      drain("R6");
      step(1'b1, 2'd1, 8'h60, 1'b1, "R6");
      chk("R6", "push_pop_on_empty", int'(head_tag), 'h60);
      drain("R6");

      // R9 / R7: fill to depth, then push while full
      for (int k = 0; k < DEPTH; k++) begin
         step(1'b1, 2'(k % NCLS), 8'(8'h70 + k), 1'b0, "R9");
         chk("R9", "full_threshold", int'(full), int'(k == DEPTH - 1));
      end
      step(1'b1, 2'd0, 8'hEE, 1'b0, "R7");
      chk("R7", "dropped_not_head", int'(head_tag == 8'hEE), 0);
      step(1'b1, 2'd0, 8'hEF, 1'b1, "R7");
      chk("R7", "pop_taken_push_dropped", int'(full), 0);
      drain("R7");

      // R8: pop on empty
      step(1'b0, '0, '0, 1'b1, "R8");
      step(1'b0, '0, '0, 1'b1, "R8");
      chk("R8", "head_zero", int'(head_tag), 0);

      // R2: long mixed traffic against the model
      for (int k = 0; k < 6000; k++) begin
         bit fill_phase = ((k / 150) % 2) == 0;
         bit pv = fill_phase ? ($urandom_range(3, 0) != 0) : ($urandom_range(3, 0) == 0);
         bit pr = fill_phase ? ($urandom_range(2, 0) == 0) : ($urandom_range(3, 0) != 0);
         step(pv, 2'($urandom_range(NCLS - 1, 0)), 8'($urandom), pr, "R2");
      end
      drain("R2");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #900000;
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule